// File: doc/BRIEF.md
# UART Register Front End

This block is the 32-bit register face of a small UART. It sits between a memory-mapped bus and the serial engine and does no serial work itself. Bytes come in from the bit-level receiver on a byte-wide strobe, together with per-byte framing and parity error flags. Bytes for the transmitter go out on a valid/ready handshake. A second address window holds the baud divisor, which is driven straight out to the tick generator.

Received bytes go into one holding register, with no queue. A byte that arrives while that register is still full is thrown away and leaves a sticky overrun mark. Software clears that mark by reading the status word or the data word. Three one-cycle interrupt pulses report a received byte, an accepted transmit write, and an overrun. Each pulse has its own static enable input, and so do the receive and transmit paths.

Bus reads are registered: read data appears one cycle after the request, and any side effects take hold at that same edge.

Top module: `uart_regfront`

## Requirements
- R1: After a synchronous reset every register reads zero, including status and baud divisor. All interrupt outputs and `tx_valid` are low.
- R2: When receive is enabled and the holder is empty (status bit 0 clear), a receive strobe latches the byte and sets status bit 0. If the receive interrupt is enabled, it also raises `irq_rx` for exactly one cycle.
- R3: Status word layout: bit 0 is receive data valid, bit 3 is transmit busy, bit 5 is overrun, bit 6 is the framing error and bit 7 is the parity error of the held byte. Bits 6 and 7 are taken from the error flags that come with an accepted byte.
- R4: A strobe that arrives while a byte is held drops the new byte and sets the sticky overrun bit. If the error interrupt is enabled, it also raises `irq_err` for exactly one cycle.
- R5: A read of window 0 offset 0x0 returns the held byte. It clears receive valid, overrun, framing error and parity error.
- R6: A read of window 0 offset 0x8 returns the status as it stood before the read and clears only the overrun bit.
- R7: With receive disabled, strobes change no state and raise no interrupt.
- R8: With transmit enabled, a write to window 0 offset 0x4 puts bits 7:0 on `tx_data` and raises `tx_valid`. If the transmit interrupt is enabled, it also raises `irq_tx` for one cycle. With transmit disabled, the write does nothing.
- R9: Transmit busy (status bit 3, equal to `tx_valid`) holds from the write until `tx_valid && tx_ready`. Transmit writes made while busy are ignored, and `tx_data` stays stable.
- R10: Window 1 offset 0x0 is the read/write baud divisor, driven on `baud_div`. Window 0 offset 0x0 does not alias it.
- R11: Only aligned accesses with all four byte enables set take effect. Any other read returns zero with no side effect, and any other write is ignored.
- R12: A strobe in the same cycle as a receive data read is accepted as a fresh byte, with no overrun. The read still returns the old byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rx_en | input | 1 | Receive path enable |
| cfg_tx_en | input | 1 | Transmit path enable |
| cfg_rx_irq_en | input | 1 | Receive interrupt enable |
| cfg_tx_irq_en | input | 1 | Transmit interrupt enable |
| cfg_err_irq_en | input | 1 | Overrun interrupt enable |
| bus_sel | input | 1 | Window select: 0 data/status, 1 baud |
| bus_addr | input | ADDR_W | Byte offset within the window |
| bus_be | input | 4 | Byte enables |
| bus_rd | input | 1 | Read request (one cycle) |
| bus_wr | input | 1 | Write request (one cycle) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| rx_strobe | input | 1 | Received byte present |
| rx_byte | input | BYTE_W | Received byte |
| rx_frame_err | input | 1 | Framing error of this byte |
| rx_parity_err | input | 1 | Parity error of this byte |
| tx_valid | output | 1 | Transmit byte offered |
| tx_data | output | BYTE_W | Transmit byte |
| tx_ready | input | 1 | Transmitter accepts byte |
| baud_div | output | DATA_W | Baud divisor value |
| irq_rx | output | 1 | Receive pulse |
| irq_tx | output | 1 | Transmit pulse |
| irq_err | output | 1 | Overrun pulse |

## Verification
The bench targets the second byte arriving into a full holder. A design that overwrote the held byte, failed to keep overrun sticky, or let a status read clear receive valid would return the wrong byte or the wrong status word. It also targets a strobe that coincides with a data read: a design that checked the stale valid flag would flag a false overrun and lose the byte. The other targets are transmit writes made while busy, which would corrupt `tx_data`; window aliasing and partial-width accesses, which would silently change the baud divisor or clear receive valid; and interrupt pulses that are not exactly one cycle wide or that ignore their enables.

// File: rtl/urf_pkg.sv
package urf_pkg;
  localparam int unsigned STAT_W   = 8;
  localparam int unsigned BE_W     = 4;
  // status bit positions (decoded by software)
  localparam int unsigned ST_RXV   = 0;
  localparam int unsigned ST_TXB   = 3;
  localparam int unsigned ST_OVR   = 5;
  localparam int unsigned ST_FRM   = 6;
  localparam int unsigned ST_PAR   = 7;
  // word indices inside the windows
  localparam int unsigned IDX_RX   = 0;
  localparam int unsigned IDX_TX   = 1;
  localparam int unsigned IDX_STAT = 2;
  localparam int unsigned IDX_BAUD = 0;

  typedef struct packed {
    logic rx;
    logic tx;
    logic stat;
    logic baud;
  } hit_t;
endpackage

// File: rtl/urf_decode.sv
module urf_decode
  import urf_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              bus_sel,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BE_W-1:0]   bus_be,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output hit_t              rd_hit,
  output hit_t              wr_hit,
  output logic              rd_any
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic             full_word;
  logic [IDX_W-1:0] idx;
  hit_t             sel_hit;

  assign idx       = bus_addr[ADDR_W-1:2];
  assign full_word = (bus_be == {BE_W{1'b1}}) && (bus_addr[1:0] == 2'b00);

  always_comb begin
    sel_hit      = '0;
    sel_hit.rx   = !bus_sel && (idx == IDX_W'(IDX_RX));
    sel_hit.tx   = !bus_sel && (idx == IDX_W'(IDX_TX));
    sel_hit.stat = !bus_sel && (idx == IDX_W'(IDX_STAT));
    sel_hit.baud =  bus_sel && (idx == IDX_W'(IDX_BAUD));
  end

  assign rd_hit = (bus_rd && full_word) ? sel_hit : '0;
  assign wr_hit = (bus_wr && full_word) ? sel_hit : '0;
  assign rd_any = bus_rd;
endmodule

// File: rtl/urf_rx_hold.sv
module urf_rx_hold #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              irq_en,
  input  logic              err_irq_en,
  input  logic              strobe,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              frame_in,
  input  logic              parity_in,
  input  logic              rd_data,
  input  logic              rd_stat,
  output logic [BYTE_W-1:0] data_q,
  output logic              valid_q,
  output logic              ovr_q,
  output logic              frm_q,
  output logic              par_q,
  output logic              irq_rx,
  output logic              irq_err
);
  // a data read frees the holder in the same cycle a new byte may land
  logic held_after_read;
  assign held_after_read = valid_q && !rd_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      ovr_q   <= 1'b0;
      frm_q   <= 1'b0;
      par_q   <= 1'b0;
      irq_rx  <= 1'b0;
      irq_err <= 1'b0;
    end else begin
      irq_rx  <= 1'b0;
      irq_err <= 1'b0;
      if (rd_data) begin
        valid_q <= 1'b0;
        ovr_q   <= 1'b0;
        frm_q   <= 1'b0;
        par_q   <= 1'b0;
      end else if (rd_stat) begin
        ovr_q   <= 1'b0;
      end
      if (en && strobe) begin
        if (held_after_read) begin
          ovr_q   <= 1'b1;
          irq_err <= err_irq_en;
        end else begin
          data_q  <= byte_in;
          valid_q <= 1'b1;
          frm_q   <= frame_in;
          par_q   <= parity_in;
          irq_rx  <= irq_en;
        end
      end
    end
  end
endmodule

// File: rtl/urf_tx_stage.sv
module urf_tx_stage #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              irq_en,
  input  logic              wr,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  output logic              irq_tx
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
      irq_tx   <= 1'b0;
    end else begin
      irq_tx <= 1'b0;
      if (tx_valid && tx_ready) begin
        tx_valid <= 1'b0;
      end
      if (wr && en && !tx_valid) begin
        tx_valid <= 1'b1;
        tx_data  <= wbyte;
        irq_tx   <= irq_en;
      end
    end
  end
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
  import urf_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_rx_en,
  input  logic              cfg_tx_en,
  input  logic              cfg_rx_irq_en,
  input  logic              cfg_tx_irq_en,
  input  logic              cfg_err_irq_en,
  input  logic              bus_sel,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_strobe,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_frame_err,
  input  logic              rx_parity_err,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] baud_div,
  output logic              irq_rx,
  output logic              irq_tx,
  output logic              irq_err
);
  hit_t              rd_hit, wr_hit;
  logic              rd_any;
  logic [BYTE_W-1:0] rx_data_q;
  logic              rx_valid_q, rx_ovr_q, rx_frm_q, rx_par_q;
  logic [STAT_W-1:0] stat_word;
  logic [DATA_W-1:0] rd_mux;

  urf_decode #(.ADDR_W(ADDR_W)) u_decode (
    .bus_sel (bus_sel),
    .bus_addr(bus_addr),
    .bus_be  (bus_be),
    .bus_rd  (bus_rd),
    .bus_wr  (bus_wr),
    .rd_hit  (rd_hit),
    .wr_hit  (wr_hit),
    .rd_any  (rd_any)
  );

  urf_rx_hold #(.BYTE_W(BYTE_W)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .en        (cfg_rx_en),
    .irq_en    (cfg_rx_irq_en),
    .err_irq_en(cfg_err_irq_en),
    .strobe    (rx_strobe),
    .byte_in   (rx_byte),
    .frame_in  (rx_frame_err),
    .parity_in (rx_parity_err),
    .rd_data   (rd_hit.rx),
    .rd_stat   (rd_hit.stat),
    .data_q    (rx_data_q),
    .valid_q   (rx_valid_q),
    .ovr_q     (rx_ovr_q),
    .frm_q     (rx_frm_q),
    .par_q     (rx_par_q),
    .irq_rx    (irq_rx),
    .irq_err   (irq_err)
  );

  urf_tx_stage #(.BYTE_W(BYTE_W)) u_tx (
    .clk     (clk),
    .rst     (rst),
    .en      (cfg_tx_en),
    .irq_en  (cfg_tx_irq_en),
    .wr      (wr_hit.tx),
    .wbyte   (bus_wdata[BYTE_W-1:0]),
    .tx_ready(tx_ready),
    .tx_valid(tx_valid),
    .tx_data (tx_data),
    .irq_tx  (irq_tx)
  );

  // status word assembly; unused positions read zero
  always_comb begin
    stat_word         = '0;
    stat_word[ST_RXV] = rx_valid_q;
    stat_word[ST_TXB] = tx_valid;
    stat_word[ST_OVR] = rx_ovr_q;
    stat_word[ST_FRM] = rx_frm_q;
    stat_word[ST_PAR] = rx_par_q;
  end

  // baud divisor register in the second window
  always_ff @(posedge clk) begin
    if (rst) begin
      baud_div <= '0;
    end else if (wr_hit.baud) begin
      baud_div <= bus_wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (1'b1)
      rd_hit.rx:   rd_mux = DATA_W'(rx_data_q);
      rd_hit.stat: rd_mux = DATA_W'(stat_word);
      rd_hit.baud: rd_mux = baud_div;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd_any) begin
      bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/urf_checker.sv
module urf_checker #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_rx_en,
  input logic              cfg_tx_en,
  input logic              cfg_rx_irq_en,
  input logic              cfg_tx_irq_en,
  input logic              cfg_err_irq_en,
  input logic              bus_sel,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [3:0]        bus_be,
  input logic              bus_rd,
  input logic              rx_strobe,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [BYTE_W-1:0] tx_data,
  input logic              irq_rx,
  input logic              irq_tx,
  input logic              irq_err,
  input logic [7:0]        stat_word
);
  logic data_read;
  assign data_read = bus_rd && !bus_sel && (bus_addr == '0) && (bus_be == 4'hF);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!irq_rx && !irq_tx && !irq_err && !tx_valid && stat_word == 8'h00));

  assert_rx_pulse_cause_R2: assert property (@(posedge clk) disable iff (rst)
    irq_rx |-> $past(rx_strobe && cfg_rx_en && cfg_rx_irq_en));

  assert_overrun_sets_R4: assert property (@(posedge clk) disable iff (rst)
    (cfg_rx_en && rx_strobe && stat_word[0] && !data_read) |=> stat_word[5]);

  assert_err_pulse_cause_R4: assert property (@(posedge clk) disable iff (rst)
    irq_err |-> $past(cfg_err_irq_en && stat_word[0] && rx_strobe));

  assert_rx_disabled_R7: assert property (@(posedge clk) disable iff (rst)
    (!cfg_rx_en && rx_strobe) |=> (!irq_rx && !irq_err));

  assert_tx_pulse_cause_R8: assert property (@(posedge clk) disable iff (rst)
    irq_tx |-> ($past(cfg_tx_en && cfg_tx_irq_en && !tx_valid) && tx_valid));

  assert_tx_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  assert_busy_bit_R9: assert property (@(posedge clk) disable iff (rst)
    stat_word[3] == tx_valid);
endmodule

bind uart_regfront urf_checker #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_urf_checker (.*);

// File: tb/test_uart_regfront.sv
module test_uart_regfront;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned BYTE_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_rx_en = 1'b1, cfg_tx_en = 1'b1;
  logic cfg_rx_irq_en = 1'b1, cfg_tx_irq_en = 1'b1, cfg_err_irq_en = 1'b1;
  logic bus_sel = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [3:0] bus_be = 4'hF;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic rx_strobe = 1'b0;
  logic [BYTE_W-1:0] rx_byte = '0;
  logic rx_frame_err = 1'b0, rx_parity_err = 1'b0;
  logic tx_valid;
  logic [BYTE_W-1:0] tx_data;
  logic tx_ready = 1'b0;
  logic [DATA_W-1:0] baud_div;
  logic irq_rx, irq_tx, irq_err;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  logic p_rx, p_tx, p_err;
  logic [DATA_W-1:0] rd;

  always #10 clk = ~clk;

  uart_regfront #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W)) i_uart_regfront (.*);

  // {expected status[7:0], parity, frame, byte[7:0]}
  localparam logic [17:0] VEC [6] = '{
    {8'h01, 1'b0, 1'b0, 8'h5A},
    {8'h41, 1'b0, 1'b1, 8'hFF},
    {8'h81, 1'b1, 1'b0, 8'h00},
    {8'hC1, 1'b1, 1'b1, 8'h81},
    {8'h01, 1'b0, 1'b0, 8'h3C},
    {8'h41, 1'b0, 1'b1, 8'hC3}
  };

  task automatic check(input string tag, input logic [DATA_W-1:0] got, input logic [DATA_W-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_read(input logic sel, input logic [ADDR_W-1:0] a, input logic [3:0] be,
                          output logic [DATA_W-1:0] d);
    @(negedge clk);
    bus_sel = sel; bus_addr = a; bus_be = be; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0; bus_be = 4'hF;
    d = bus_rdata;
  endtask

  task automatic bus_write(input logic sel, input logic [ADDR_W-1:0] a, input logic [3:0] be,
                           input logic [DATA_W-1:0] d);
    @(negedge clk);
    bus_sel = sel; bus_addr = a; bus_be = be; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = 4'hF;
    p_tx = irq_tx;
  endtask

  task automatic rx_send(input logic [7:0] b, input logic fe, input logic pe);
    @(negedge clk);
    rx_strobe = 1'b1; rx_byte = b; rx_frame_err = fe; rx_parity_err = pe;
    @(negedge clk);
    rx_strobe = 1'b0; rx_frame_err = 1'b0; rx_parity_err = 1'b0;
    p_rx = irq_rx; p_err = irq_err;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq_rx", DATA_W'(irq_rx), 0);
    check("R1 tx_valid", DATA_W'(tx_valid), 0);
    check("R1 baud_div", baud_div, 0);
    bus_read(0, 4'h8, 4'hF, rd); check("R1 status", rd, 0);
    bus_read(1, 4'h0, 4'hF, rd); check("R1 baud read", rd, 0);

    // table walk: R2 R3 R5
    foreach (VEC[i]) begin
      rx_send(VEC[i][7:0], VEC[i][8], VEC[i][9]);
      check("R2 rx pulse", DATA_W'(p_rx), 1);
      bus_read(0, 4'h8, 4'hF, rd); check("R3 status bits", rd, DATA_W'(VEC[i][17:10]));
      bus_read(0, 4'h0, 4'hF, rd); check("R5 rx data", rd, DATA_W'(VEC[i][7:0]));
      bus_read(0, 4'h8, 4'hF, rd); check("R5 status cleared", rd, 0);
    end

    // R2 pulse width
    rx_send(8'h10, 0, 0);
    @(negedge clk); check("R2 pulse one cycle", DATA_W'(irq_rx), 0);
    bus_read(0, 4'h0, 4'hF, rd);

    // R4 overrun, R6 status read side effect
    rx_send(8'h11, 0, 0);
    rx_send(8'h22, 0, 0);
    check("R4 err pulse", DATA_W'(p_err), 1);
    check("R4 no rx pulse", DATA_W'(p_rx), 0);
    @(negedge clk); check("R4 err pulse one cycle", DATA_W'(irq_err), 0);
    bus_read(0, 4'h8, 4'hF, rd); check("R6 status with overrun", rd, 32'h21);
    bus_read(0, 4'h8, 4'hF, rd); check("R6 overrun cleared by status read", rd, 32'h01);
    bus_read(0, 4'h0, 4'hF, rd); check("R4 first byte kept", rd, 32'h11);
    bus_read(0, 4'h8, 4'hF, rd); check("R5 empty after read", rd, 0);

    // R5 data read clears overrun
    rx_send(8'h33, 0, 0);
    rx_send(8'h44, 1, 1);
    bus_read(0, 4'h0, 4'hF, rd); check("R5 held byte", rd, 32'h33);
    bus_read(0, 4'h8, 4'hF, rd); check("R5 overrun cleared by data read", rd, 0);

    // R12 strobe coinciding with data read
    rx_send(8'h55, 0, 0);
    @(negedge clk);
    bus_sel = 0; bus_addr = 4'h0; bus_be = 4'hF; bus_rd = 1'b1;
    rx_strobe = 1'b1; rx_byte = 8'h66;
    @(negedge clk);
    bus_rd = 1'b0; rx_strobe = 1'b0;
    check("R12 read returns old byte", bus_rdata, 32'h55);
    check("R12 fresh byte pulses rx", DATA_W'(irq_rx), 1);
    bus_read(0, 4'h8, 4'hF, rd); check("R12 no overrun", rd, 32'h01);
    bus_read(0, 4'h0, 4'hF, rd); check("R12 new byte", rd, 32'h66);

    // interrupt enables off
    cfg_rx_irq_en = 1'b0; cfg_err_irq_en = 1'b0;
    rx_send(8'h77, 0, 0); check("R2 rx pulse masked", DATA_W'(p_rx), 0);
    rx_send(8'h78, 0, 0); check("R4 err pulse masked", DATA_W'(p_err), 0);
    bus_read(0, 4'h8, 4'hF, rd); check("R4 overrun without irq", rd, 32'h21);
    bus_read(0, 4'h0, 4'hF, rd); check("R2 masked byte latched", rd, 32'h77);
    cfg_rx_irq_en = 1'b1; cfg_err_irq_en = 1'b1;

    // R7 receive disabled
    cfg_rx_en = 1'b0;
    rx_send(8'h99, 1, 1);
    check("R7 no rx pulse", DATA_W'(p_rx), 0);
    bus_read(0, 4'h8, 4'hF, rd); check("R7 status untouched", rd, 0);
    cfg_rx_en = 1'b1;

    // R8 / R9 transmit
    bus_write(0, 4'h4, 4'hF, 32'h123456A5);
    check("R8 tx pulse", DATA_W'(p_tx), 1);
    check("R8 tx_valid", DATA_W'(tx_valid), 1);
    check("R8 tx_data low byte", DATA_W'(tx_data), 32'hA5);
    bus_read(0, 4'h8, 4'hF, rd); check("R9 busy bit", rd, 32'h08);
    bus_write(0, 4'h4, 4'hF, 32'hBB);
    check("R9 write while busy ignored", DATA_W'(tx_data), 32'hA5);
    check("R9 no pulse while busy", DATA_W'(p_tx), 0);
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
    check("R9 handshake ends busy", DATA_W'(tx_valid), 0);
    bus_read(0, 4'h8, 4'hF, rd); check("R9 busy cleared", rd, 0);
    cfg_tx_en = 1'b0;
    bus_write(0, 4'h4, 4'hF, 32'hCC);
    check("R8 disabled no valid", DATA_W'(tx_valid), 0);
    check("R8 disabled no pulse", DATA_W'(p_tx), 0);
    cfg_tx_en = 1'b1;

    // R10 baud window
    bus_write(1, 4'h0, 4'hF, 32'h00001B20);
    bus_read(1, 4'h0, 4'hF, rd); check("R10 baud readback", rd, 32'h1B20);
    check("R10 baud_div port", baud_div, 32'h1B20);
    bus_write(0, 4'h0, 4'hF, 32'hFFFF);
    bus_read(1, 4'h0, 4'hF, rd); check("R10 no alias", rd, 32'h1B20);

    // R11 partial / misaligned access
    bus_write(1, 4'h0, 4'h3, 32'h55);
    bus_read(1, 4'h0, 4'hF, rd); check("R11 partial write ignored", rd, 32'h1B20);
    bus_write(1, 4'h1, 4'hF, 32'h66);
    check("R11 misaligned write ignored", baud_div, 32'h1B20);
    rx_send(8'hAB, 0, 0);
    bus_read(0, 4'h0, 4'h1, rd); check("R11 partial read zero", rd, 0);
    bus_read(0, 4'h8, 4'hF, rd); check("R11 partial read no side effect", rd, 32'h01);

    // R1 reset from a loaded state
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 baud after reset", baud_div, 0);
    bus_read(0, 4'h8, 4'hF, rd); check("R1 status after reset", rd, 0);
    bus_read(0, 4'h0, 4'hF, rd); check("R1 rx data after reset", rd, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule